// File: doc/BRIEF.md
# Bit-Serial Receive FIFO with Serial Status Readout

This block collects the data bits a demodulator recovers, one per strobe, into a circular bit store. A host empties it with a serial read. The host lowers chip select and clocks in an 8-bit command. When the command is the read code, the block answers with a fixed 40-bit frame: 32 data bits, oldest first, then a status byte. The status byte carries an overflow flag and the number of those 32 bits that are valid. Only a read that runs to its 40th bit consumes data. The read pointer then moves forward by the valid count, and any remaining bits lead the next frame.

The store is emptied (both pointers and the fill level return to zero) by three kinds of event. The first is a frame-start pulse that arrives while an overflow is pending. The second is a frame-start pulse with the per-frame option on and the lock off. The third is an operating-mode change with the per-cycle option on. A lock input freezes the contents against new bits. An end-of-message strobe produces an interrupt with selectable polarity. With the lock off the interrupt is a single-cycle pulse. With the lock on it stays active until a read completes.

The serial clock, chip select and data-in are expected already synchronised to `clk`. The block samples them and detects serial clock edges itself.

Top module: `serial_bit_fifo`

## Requirements
- R1: A read starts with 8 command bits on `spi_sdi`, most significant first, each taken at a rising `spi_sck`. When they equal `RD_CMD` (default 8'h96), each of the next 40 rising edges advances `spi_sdo` one position. The host samples before each edge and sees D0 to D31 (oldest stored bit first), then status bits S7 down to S0.
- R2: Status bits S5..S0 equal the smaller of 32 and the number of bits stored when the command completed. Data positions at or above that count read 0. S6 has no meaning and is not checked.
- R3: A read that reaches its 40th bit removes exactly the counted bits. The bits left over open the next frame in their original order.
- R4: `spi_sdo_oe` is 1 only during the 40-bit answer of a matching read. It stays 0 during the command, after the answer and for any other command. A non-matching command consumes nothing.
- R5: A bit offered while `DEPTH` bits are held sets the overflow flag, reported in S7, and the bit is discarded. The flag stays set through later reads.
- R6: A `frame_start` pulse while overflow is set clears the flag and empties the store, whatever the option and lock inputs are.
- R7: With `frame_init_en` = 1, a `frame_start` pulse empties the store only while `lock` = 0. With the lock set, or the option off (and no overflow), the contents stay.
- R8: `mode` is encoded 0 = sleep, 1 = self-polling, 2 = run-self-polling, 3 = run-slave. With `cycle_init_en` = 1 the store is emptied on entering 3 from any other mode, and on a change from 1 to 2. Other changes, or the option off, leave it intact.
- R9: While `lock` = 1, strobes on `bit_we` store nothing.
- R10: `eom` makes `irq` active in the next cycle. Active means equal to `irq_pol`, so `irq_pol` = 1 selects active high. With `lock` = 0 the activity lasts one cycle. With `lock` = 1 it lasts until a read completes.
- R11: A bit written in the same cycle a read completes is kept. The fill level becomes old level + 1 − count.
- R12: After reset the store is empty, the overflow flag is clear, `spi_sdo_oe` is 0 and `irq` is inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_we | input | 1 | Strobe: store `bit_d` this cycle |
| bit_d | input | 1 | Demodulated data bit |
| frame_start | input | 1 | Frame-start detection pulse |
| mode | input | 2 | Operating mode code (see R8) |
| cycle_init_en | input | 1 | Empty the store on qualifying mode changes |
| frame_init_en | input | 1 | Empty the store on frame start when unlocked |
| lock | input | 1 | Freeze contents against new bits |
| eom | input | 1 | End-of-message strobe |
| irq_pol | input | 1 | Interrupt active level (1 = high) |
| spi_cs_n | input | 1 | Serial chip select, active low |
| spi_sck | input | 1 | Serial clock, sampled by `clk` |
| spi_sdi | input | 1 | Serial command input |
| spi_sdo | output | 1 | Serial answer data |
| spi_sdo_oe | output | 1 | Answer drive enable (0 = high impedance) |
| irq | output | 1 | Interrupt output |

## Verification
Two functions can act on the fill level in the same clock. A new bit can be written in the cycle where a completed read retires its count. The bench provokes this on the last bit of a read. It raises the serial clock and holds the write strobe for three clocks, so one write lands in the retire cycle. It then checks that the next frame reports exactly those three bits, in order, as the only content. A second coincidence is a frame-start pulse while locked and overflowed. The bench checks that the overflow clear wins over the lock.

// File: rtl/bitfifo_pkg.sv
package bitfifo_pkg;
  typedef enum logic [1:0] {
    MD_SLEEP         = 2'd0,
    MD_SELF_POLL     = 2'd1,
    MD_RUN_SELF_POLL = 2'd2,
    MD_RUN_SLAVE     = 2'd3
  } op_mode_e;
endpackage

// File: rtl/bitfifo_store.sv
module bitfifo_store #(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned BURST = 32,
  parameter int unsigned PW    = 6,
  parameter int unsigned CW    = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_bit,
  input  logic             lock,
  input  logic             init,
  input  logic             rd_done,
  input  logic [CW-1:0]    rd_cnt,
  output logic [BURST-1:0] burst_data,
  output logic [CW-1:0]    burst_cnt,
  output logic             ovf
);
  localparam int unsigned LW = PW + 1;

  logic [PW-1:0]    wr_ptr_q, wr_ptr_d, rd_ptr_q, rd_ptr_d;
  logic [LW-1:0]    level_q, level_d;
  logic             ovf_q, ovf_d;
  logic [DEPTH-1:0] mem_q;
  logic             wr_try, room, wr_ok, rd_take;

  assign wr_try  = wr_en & ~lock & ~ovf_q & ~init;
  assign room    = (level_q != LW'(DEPTH)) | (rd_done & (rd_cnt != '0));
  assign wr_ok   = wr_try & room;
  assign rd_take = rd_done & ~ovf_q & ~init;

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    level_d  = level_q;
    ovf_d    = ovf_q;
    if (init) begin
      wr_ptr_d = '0;
      rd_ptr_d = '0;
      level_d  = '0;
      ovf_d    = 1'b0;
    end else begin
      if (wr_ok) begin
        wr_ptr_d = wr_ptr_q + PW'(1);
      end
      if (rd_take) begin
        rd_ptr_d = rd_ptr_q + PW'(rd_cnt);
      end
      level_d = level_q + (wr_ok ? LW'(1) : '0) - (rd_take ? LW'(rd_cnt) : '0);
      if (wr_try & ~room) begin
        ovf_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      level_q  <= '0;
      ovf_q    <= 1'b0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      level_q  <= level_d;
      ovf_q    <= ovf_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_ok) begin
      mem_q[wr_ptr_q] <= wr_bit;
    end
  end

  // gather the next burst, oldest bit at index 0, unfilled slots forced low
  always_comb begin
    for (int i = 0; i < BURST; i++) begin
      burst_data[i] = mem_q[rd_ptr_q + PW'(i)] & (LW'(i) < level_q);
    end
  end

  assign burst_cnt = (level_q >= LW'(BURST)) ? CW'(BURST) : CW'(level_q);
  assign ovf       = ovf_q;

  p_level_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    level_q <= LW'(DEPTH));

  p_init_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
    init |=> (level_q == '0) && !ovf_q);

  p_lock_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (lock && wr_en && !rd_done && !init) |=> level_q == $past(level_q));

  p_same_cycle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_done && wr_en && !lock && !ovf_q && !init && level_q < LW'(DEPTH))
    |=> level_q == $past(level_q) + LW'(1) - LW'($past(rd_cnt)));
endmodule

// File: rtl/bitfifo_spi.sv
module bitfifo_spi #(
  parameter int unsigned BURST  = 32,
  parameter int unsigned CW     = 6,
  parameter int unsigned CMD_W  = 8,
  parameter logic [7:0]  RD_CMD = 8'h96
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             sck,
  input  logic             sdi,
  input  logic             init,
  input  logic [BURST-1:0] ld_data,
  input  logic [CW-1:0]    ld_cnt,
  input  logic             ld_ovf,
  output logic             sdo,
  output logic             sdo_oe,
  output logic             rd_done,
  output logic [CW-1:0]    rd_cnt
);
  localparam int unsigned STAT_W  = CW + 2;
  localparam int unsigned FRAME_W = BURST + STAT_W;
  localparam int unsigned LAST    = CMD_W + FRAME_W - 1;
  localparam int unsigned BCW     = $clog2(LAST + 2);

  logic               sck_q, rise;
  logic [BCW-1:0]     bitcnt_q, bitcnt_d;
  logic [CMD_W-1:0]   cmd_q, cmd_d, cmd_next;
  logic [FRAME_W-1:0] sh_q, sh_d, load;
  logic               oe_q, oe_d, armed_q, armed_d, done_q, done_d;
  logic [CW-1:0]      cnt_q, cnt_d;

  assign rise     = sck & ~sck_q;
  assign cmd_next = {cmd_q[CMD_W-2:0], sdi};

  // data leaves oldest first, then the status byte from its top bit down
  always_comb begin
    load = '0;
    for (int i = 0; i < BURST; i++) begin
      load[FRAME_W-1-i] = ld_data[i];
    end
    load[STAT_W-1:0] = {ld_ovf, 1'b0, ld_cnt};
  end

  always_comb begin
    bitcnt_d = bitcnt_q;
    cmd_d    = cmd_q;
    sh_d     = sh_q;
    oe_d     = oe_q;
    armed_d  = armed_q;
    cnt_d    = cnt_q;
    done_d   = 1'b0;
    if (cs_n) begin
      bitcnt_d = '0;
      oe_d     = 1'b0;
      armed_d  = 1'b0;
    end else if (rise) begin
      if (bitcnt_q < BCW'(CMD_W)) begin
        cmd_d    = cmd_next;
        bitcnt_d = bitcnt_q + BCW'(1);
        if ((bitcnt_q == BCW'(CMD_W - 1)) && (cmd_next == RD_CMD)) begin
          sh_d    = load;
          oe_d    = 1'b1;
          armed_d = 1'b1;
          cnt_d   = ld_cnt;
        end
      end else if (oe_q) begin
        sh_d     = {sh_q[FRAME_W-2:0], 1'b0};
        bitcnt_d = bitcnt_q + BCW'(1);
        if (bitcnt_q == BCW'(LAST)) begin
          oe_d    = 1'b0;
          done_d  = armed_q;
          armed_d = 1'b0;
        end
      end
    end
    if (init) begin
      armed_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q    <= 1'b0;
      bitcnt_q <= '0;
      cmd_q    <= '0;
      sh_q     <= '0;
      oe_q     <= 1'b0;
      armed_q  <= 1'b0;
      cnt_q    <= '0;
      done_q   <= 1'b0;
    end else begin
      sck_q    <= sck;
      bitcnt_q <= bitcnt_d;
      cmd_q    <= cmd_d;
      sh_q     <= sh_d;
      oe_q     <= oe_d;
      armed_q  <= armed_d;
      cnt_q    <= cnt_d;
      done_q   <= done_d;
    end
  end

  assign sdo     = sh_q[FRAME_W-1];
  assign sdo_oe  = oe_q;
  assign rd_done = done_q;
  assign rd_cnt  = cnt_q;

  p_idle_hiz_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> !sdo_oe);

  p_done_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done |=> !rd_done);

  p_done_closes_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done |-> !sdo_oe);
endmodule

// File: rtl/bitfifo_ctrl.sv
module bitfifo_ctrl
  import bitfifo_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode,
  input  logic       cycle_init_en,
  input  logic       frame_init_en,
  input  logic       frame_start,
  input  logic       lock,
  input  logic       ovf,
  input  logic       eom,
  input  logic       irq_pol,
  input  logic       rd_done,
  output logic       init,
  output logic       irq
);
  op_mode_e mode_q, mode_cur;
  logic     cyc_evt, frame_evt, ovf_evt;
  logic     hold_q, hold_d, pulse_q, active;

  assign mode_cur  = op_mode_e'(mode);
  assign cyc_evt   = cycle_init_en &
                     (((mode_cur == MD_RUN_SLAVE) && (mode_q != MD_RUN_SLAVE)) ||
                      ((mode_q == MD_SELF_POLL) && (mode_cur == MD_RUN_SELF_POLL)));
  assign frame_evt = frame_start & frame_init_en & ~lock;
  assign ovf_evt   = frame_start & ovf;
  assign init      = cyc_evt | frame_evt | ovf_evt;

  always_comb begin
    hold_d = hold_q;
    if (eom && lock) begin
      hold_d = 1'b1;
    end else if (rd_done) begin
      hold_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= MD_SLEEP;
      hold_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      mode_q  <= mode_cur;
      hold_q  <= hold_d;
      pulse_q <= eom;
    end
  end

  assign active = pulse_q | hold_q;
  assign irq    = irq_pol ? active : ~active;

  p_eom_raise_r10: assert property (@(posedge clk) disable iff (!rst_n)
    eom |=> irq == irq_pol);

  p_eom_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (eom && lock) ##1 !rd_done |=> irq == irq_pol);
endmodule

// File: rtl/serial_bit_fifo.sv
module serial_bit_fifo #(
  parameter int unsigned DEPTH  = 64,
  parameter int unsigned BURST  = 32,
  parameter logic [7:0]  RD_CMD = 8'h96
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_we,
  input  logic       bit_d,
  input  logic       frame_start,
  input  logic [1:0] mode,
  input  logic       cycle_init_en,
  input  logic       frame_init_en,
  input  logic       lock,
  input  logic       eom,
  input  logic       irq_pol,
  input  logic       spi_cs_n,
  input  logic       spi_sck,
  input  logic       spi_sdi,
  output logic       spi_sdo,
  output logic       spi_sdo_oe,
  output logic       irq
);
  localparam int unsigned PW = $clog2(DEPTH);
  localparam int unsigned CW = $clog2(BURST + 1);

  logic             init, ovf, rd_done;
  logic [CW-1:0]    rd_cnt, burst_cnt;
  logic [BURST-1:0] burst_data;

  bitfifo_store #(.DEPTH(DEPTH), .BURST(BURST), .PW(PW), .CW(CW)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (bit_we),
    .wr_bit     (bit_d),
    .lock       (lock),
    .init       (init),
    .rd_done    (rd_done),
    .rd_cnt     (rd_cnt),
    .burst_data (burst_data),
    .burst_cnt  (burst_cnt),
    .ovf        (ovf)
  );

  bitfifo_spi #(.BURST(BURST), .CW(CW), .CMD_W(8), .RD_CMD(RD_CMD)) u_spi (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs_n    (spi_cs_n),
    .sck     (spi_sck),
    .sdi     (spi_sdi),
    .init    (init),
    .ld_data (burst_data),
    .ld_cnt  (burst_cnt),
    .ld_ovf  (ovf),
    .sdo     (spi_sdo),
    .sdo_oe  (spi_sdo_oe),
    .rd_done (rd_done),
    .rd_cnt  (rd_cnt)
  );

  bitfifo_ctrl u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .mode          (mode),
    .cycle_init_en (cycle_init_en),
    .frame_init_en (frame_init_en),
    .frame_start   (frame_start),
    .lock          (lock),
    .ovf           (ovf),
    .eom           (eom),
    .irq_pol       (irq_pol),
    .rd_done       (rd_done),
    .init          (init),
    .irq           (irq)
  );

  p_reset_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !spi_sdo_oe);
endmodule

// File: tb/test_serial_bit_fifo.sv
module test_serial_bit_fifo;
  localparam int CLK_P = 10;
  localparam logic [7:0] RD = 8'h96;
  localparam int NV = 6;
  localparam int VN [NV] = '{5, 32, 0, 40, 3, 1};
  localparam logic [63:0] VP [NV] = '{
    64'h0000_0000_0000_000D, 64'h0000_0000_A5C3_0F96,
    64'h0,                   64'h0000_00F0_1234_5678,
    64'h0000_0000_0000_0005, 64'h1};
  localparam int VC [NV] = '{5, 32, 0, 32, 11, 1};

  logic clk = 1'b0, rst_n = 1'b0;
  logic bit_we = 0, bit_d = 0, frame_start = 0, cycle_init_en = 0, frame_init_en = 0;
  logic lock = 0, eom = 0, irq_pol = 1, cs_n = 1, sck = 0, sdi = 0;
  logic [1:0] mode = 2'd0;
  logic sdo, sdo_oe, irq;

  int n_chk = 0, n_fail = 0;
  bit mq[$];
  bit movf = 0;
  logic [31:0] rd_data;
  logic [7:0]  rd_stat;
  logic oe_cmd, oe_all, oe_any, oe_end;

  always #(CLK_P/2) clk = ~clk;

  serial_bit_fifo i_serial_bit_fifo (
    .clk(clk), .rst_n(rst_n), .bit_we(bit_we), .bit_d(bit_d),
    .frame_start(frame_start), .mode(mode), .cycle_init_en(cycle_init_en),
    .frame_init_en(frame_init_en), .lock(lock), .eom(eom), .irq_pol(irq_pol),
    .spi_cs_n(cs_n), .spi_sck(sck), .spi_sdi(sdi), .spi_sdo(sdo),
    .spi_sdo_oe(sdo_oe), .irq(irq));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic m_push(input bit b);
    if (lock || movf) return;
    if (mq.size() == 64) movf = 1;
    else mq.push_back(b);
  endtask

  task automatic m_clear();
    mq.delete();
    movf = 0;
  endtask

  task automatic write_bits(input int n, input logic [63:0] pat);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      bit_we = 1;
      bit_d  = pat[i % 64];
      m_push(pat[i % 64]);
    end
    @(negedge clk);
    bit_we = 0;
  endtask

  task automatic spi_read(input logic [7:0] cmd, input int late_n);
    logic [39:0] fr;
    fr = '0;
    oe_cmd = 0; oe_all = 1; oe_any = 0;
    @(negedge clk);
    cs_n = 0; sck = 0;
    repeat (3) @(negedge clk);
    for (int k = 0; k < 48; k++) begin
      if (k >= 8) begin
        fr[39-(k-8)] = sdo;
        if (!sdo_oe) oe_all = 0;
      end else if (sdo_oe) begin
        oe_cmd = 1;
      end
      if (sdo_oe) oe_any = 1;
      sdi = (k < 8) ? cmd[7-k] : 1'b0;
      sck = 1;
      if (k == 47 && late_n > 0) begin
        bit_we = 1;
        for (int j = 0; j < late_n; j++) begin
          bit_d = ~j[0];
          @(negedge clk);
        end
        bit_we = 0;
      end else begin
        repeat (3) @(negedge clk);
      end
      sck = 0;
      repeat (3) @(negedge clk);
    end
    oe_end = sdo_oe;
    cs_n = 1;
    @(negedge clk);
    rd_data = '0;
    for (int i = 0; i < 32; i++) rd_data[i] = fr[39-i];
    rd_stat = fr[7:0];
  endtask

  task automatic read_check(input string req, input int late_n);
    int en;
    bit eo;
    logic [31:0] ed;
    en = (mq.size() < 32) ? mq.size() : 32;
    eo = movf;
    spi_read(RD, late_n);
    chk({req, "/R5 S7"}, rd_stat[7], eo);
    chk("R4 enable", {oe_cmd, oe_all, oe_end}, 3'b010);
    if (!eo) begin
      ed = '0;
      for (int i = 0; i < en; i++) ed[i] = mq[i];
      chk({req, "/R2 count"}, rd_stat[5:0], en);
      chk({req, "/R1 data"}, rd_data, ed);
      for (int i = 0; i < en; i++) void'(mq.pop_front());
    end
    for (int j = 0; j < late_n; j++) m_push(~j[0]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R12 oe in reset", sdo_oe, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk("R12 irq idle", irq, 0);
    chk("R12 oe idle", sdo_oe, 0);
    read_check("R12", 0);

    // vector table: R1 R2 R3
    for (int v = 0; v < NV; v++) begin
      write_bits(VN[v], VP[v]);
      read_check("R3", 0);
      chk("R2 table count", rd_stat[5:0], VC[v]);
    end

    // R4: foreign command drives nothing, consumes nothing
    write_bits(4, 64'h9);
    spi_read(8'h00, 0);
    chk("R4 foreign cmd", {oe_any, oe_end}, 2'b00);
    read_check("R4", 0);

    // R9: locked writes dropped
    lock = 1;
    write_bits(5, 64'h1F);
    read_check("R9", 0);
    lock = 0;

    // R5 then R6: overflow, persist, clear by frame start even when locked
    write_bits(65, 64'hDEAD_BEEF_0123_4567);
    chk("R5 model", movf, 1);
    read_check("R5", 0);
    read_check("R5", 0);
    lock = 1;
    @(negedge clk); frame_start = 1;
    @(negedge clk); frame_start = 0; lock = 0; m_clear();
    read_check("R6", 0);

    // R7: frame-start init
    frame_init_en = 1;
    write_bits(6, 64'h2D);
    @(negedge clk); frame_start = 1;
    @(negedge clk); frame_start = 0; m_clear();
    read_check("R7", 0);
    write_bits(6, 64'h35);
    lock = 1;
    @(negedge clk); frame_start = 1;
    @(negedge clk); frame_start = 0;
    read_check("R7", 0);
    chk("R7 locked keep", rd_stat[5:0], 6);
    lock = 0; frame_init_en = 0;
    write_bits(3, 64'h6);
    @(negedge clk); frame_start = 1;
    @(negedge clk); frame_start = 0;
    read_check("R7", 0);
    chk("R7 option off", rd_stat[5:0], 3);

    // R8: mode-change init
    cycle_init_en = 1;
    write_bits(5, 64'h15);
    @(negedge clk); mode = 2'd3; m_clear();
    read_check("R8", 0);
    chk("R8 enter run-slave", rd_stat[5:0], 0);
    @(negedge clk); mode = 2'd1;
    write_bits(5, 64'h0B);
    @(negedge clk); mode = 2'd2; m_clear();
    read_check("R8", 0);
    chk("R8 self to run-self", rd_stat[5:0], 0);
    write_bits(4, 64'hC);
    @(negedge clk); mode = 2'd1;
    read_check("R8", 0);
    chk("R8 no trigger", rd_stat[5:0], 4);
    cycle_init_en = 0;
    write_bits(2, 64'h2);
    @(negedge clk); mode = 2'd3;
    read_check("R8", 0);
    chk("R8 option off", rd_stat[5:0], 2);

    // R10: interrupt
    @(negedge clk); eom = 1;
    @(negedge clk); eom = 0;
    chk("R10 pulse", irq, 1);
    repeat (3) @(negedge clk);
    chk("R10 pulse ends", irq, 0);
    lock = 1;
    @(negedge clk); eom = 1;
    @(negedge clk); eom = 0;
    repeat (10) @(negedge clk);
    chk("R10 held", irq, 1);
    read_check("R10", 0);
    chk("R10 released", irq, 0);
    lock = 0;
    irq_pol = 0;
    @(negedge clk);
    chk("R10 low-active idle", irq, 1);
    @(negedge clk); eom = 1;
    @(negedge clk); eom = 0;
    chk("R10 low-active pulse", irq, 0);
    irq_pol = 1;

    // R11: write lands in the retire cycle
    write_bits(3, 64'h5);
    read_check("R11", 3);
    read_check("R11", 0);
    chk("R11 count", rd_stat[5:0], 3);
    chk("R11 data", rd_data[2:0], 3'b101);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule